// File: doc/BRIEF.md
# Serial EEPROM Block Reader

This block is a two-wire bus master that reads a run of bytes from a serial EEPROM. The run always starts at memory address zero. A one-cycle `start` pulse and a byte `count` begin a read. The block first checks that the data line is free. If a device is still holding the line low, the block clocks it free. The block then uses a dummy write to set the word address to zero, sends a repeated START, and reads the bytes in sequence. Each byte is handed out with a one-cycle strobe. The read closes with a STOP condition that is retried until the data line is seen high.

Both bus lines are driven through pull-down enables. A control bit of 1 pulls the line low, and a 0 releases it. The sensed data input is the true line level. Bus timing is built from fixed slots of `HALF_CYC` clock cycles each. A clock pulse takes three slots, and SDA is sampled on the last cycle of the slot in which SCL is released.

Top module: `eeprom_seq_reader`

## Requirements
- R1: After reset, `scl_ctl` and `sda_ctl` are 0 (both lines released), and `busy`, `done` and `rx_valid` are 0. While `busy` is 0, both control outputs stay 0.
- R2: A `start` pulse seen while idle sets `busy` in the next cycle. The first slot leaves both lines released, and SDA is sampled at the end of that slot. If SDA reads high, the next slot is START: `sda_ctl`=1 with `scl_ctl`=0. Each slot lasts exactly `HALF_CYC` cycles.
- R3: Every bit is one clock pulse of three slots. The first slot pulls SCL low and keeps the previous SDA value. The second slot keeps SCL low and puts the new SDA value out. The third slot releases SCL and keeps SDA. Bytes go out MSB first, and a 1 bit is sent as `sda_ctl`=0. SDA changes while SCL is released only for START and STOP.
- R4: The bus order is START, 0xA0, ACK, 0x00, ACK, then one pulse with SDA released followed by a repeated START, then 0xA1, ACK, then `count` received bytes, then STOP.
- R5: If the first sample reads SDA low, the block issues pulses with SDA released and samples after each one. It goes to START at the first high sample. If all 10 samples read low, the block ends with `ok`=0 and does not issue a START.
- R6: An ACK pulse keeps SDA released. If SDA reads high at the ACK sample, the transaction ends right after that pulse with `ok`=0, and no further pulse is issued.
- R7: After the eighth bit of a received byte is sampled, the byte (MSB first) appears on `rx_data` with `rx_valid` high for exactly one cycle. That cycle is the first cycle of the acknowledge pulse. The block drives that pulse with `sda_ctl`=1 for every byte except the last, and with `sda_ctl`=0 for the last.
- R8: STOP is one pulse with `sda_ctl`=1, followed by one slot with both lines released, and SDA is sampled at the end of that slot. If SDA reads low, the whole STOP is repeated. After 10 low samples the block ends with `ok`=0. A high sample ends the block with `ok`=1.
- R9: `done` is high for one cycle, in the cycle right after the final slot. In that same cycle `busy` falls, both lines are released, and `ok` gives the result.
- R10: While `busy` is 1, `start` and `count` are ignored. The transaction already running is not changed, and no second transaction follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a read; acted on only when idle |
| count | input | CNT_W | Number of bytes to read; latched at start |
| scl_ctl | output | 1 | Clock line pull-down enable (1 = line low) |
| sda_ctl | output | 1 | Data line pull-down enable (1 = line low) |
| sda_in | input | 1 | Sensed data line level |
| busy | output | 1 | Transaction in progress |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| done | output | 1 | One-cycle end-of-transaction strobe |
| ok | output | 1 | Result qualified by done: 1 = success |

## Verification
All output timing depends on the number of slots, so the expected output in every cycle is known. `busy` is due one cycle after an accepted `start`. Each bus level holds for `HALF_CYC` cycles from a slot boundary. `rx_valid` is due in the first cycle after the slot that samples a byte's last bit, and `done` in the first cycle after the final slot. The bench builds the whole per-cycle trace from the requirements before each run. It then compares the lines, `busy`, the byte strobe and the result against that trace at every falling edge. At the same edges it drives the sensed data line from the trace, so each sample the design takes at a rising edge sees a settled value.

// File: rtl/eeprom_seq_reader.sv
module eeprom_seq_reader #(
  parameter int HALF_CYC = 1000,
  parameter int CNT_W    = 8,
  parameter int TRIES    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  output logic             scl_ctl,
  output logic             sda_ctl,
  input  logic             sda_in,
  output logic             busy,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             done,
  output logic             ok
);
  localparam int TW = $clog2(HALF_CYC + 1);
  localparam int RW = $clog2(TRIES + 1);
  localparam logic [7:0] DEV_WR = 8'hA0;
  localparam logic [7:0] DEV_RD = 8'hA1;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_REC, S_STA, S_TX, S_TACK, S_RPRE, S_RX, S_MACK, S_STP, S_SCHK
  } st_t;

  st_t              st;
  logic [1:0]       ph;
  logic [TW-1:0]    tmr;
  logic [2:0]       bitn;
  logic [1:0]       seq;
  logic [7:0]       shreg;
  logic [CNT_W-1:0] cnt_q, nrx;
  logic [RW-1:0]    tries;
  logic             d_cur;

  wire tick     = (tmr == TW'(HALF_CYC - 1));
  wire try_end  = (tries == RW'(TRIES - 1));
  wire last     = ({1'b0, nrx} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, cnt_q};
  wire pulse_st = st inside {S_REC, S_TX, S_TACK, S_RPRE, S_RX, S_MACK, S_STP};

  always_comb begin
    case (st)
      S_TX:    d_cur = ~shreg[7];
      S_MACK:  d_cur = ~last;
      S_STP:   d_cur = 1'b1;
      default: d_cur = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; tmr <= '0; bitn <= '0; seq <= '0; shreg <= '0;
      cnt_q <= '0; nrx <= '0; tries <= '0; scl_ctl <= 1'b0; sda_ctl <= 1'b0;
      busy <= 1'b0; rx_data <= '0; rx_valid <= 1'b0; done <= 1'b0; ok <= 1'b0;
    end else begin
      done <= 1'b0;
      rx_valid <= 1'b0;
      if (st == S_IDLE) begin
        tmr <= '0;
        if (start) begin
          st <= S_CHK; busy <= 1'b1; ok <= 1'b0; seq <= '0; nrx <= '0; cnt_q <= count;
        end
      end else begin
        tmr <= tick ? '0 : tmr + 1'b1;
        if (tick) begin
          if (pulse_st && ph == 2'd0) begin
            sda_ctl <= d_cur; ph <= 2'd1;
          end else if (pulse_st && ph == 2'd1) begin
            scl_ctl <= 1'b0; ph <= 2'd2;
          end else begin
            case (st)
              S_CHK: begin
                if (sda_in) begin
                  sda_ctl <= 1'b1; st <= S_STA;
                end else begin
                  st <= S_REC; tries <= '0; scl_ctl <= 1'b1; ph <= 2'd0;
                end
              end
              S_REC: begin
                if (sda_in) begin
                  sda_ctl <= 1'b1; st <= S_STA;
                end else if (try_end) begin
                  st <= S_IDLE; busy <= 1'b0; done <= 1'b1; ok <= 1'b0;
                  scl_ctl <= 1'b0; sda_ctl <= 1'b0;
                end else begin
                  tries <= tries + 1'b1; scl_ctl <= 1'b1; ph <= 2'd0;
                end
              end
              S_STA: begin
                shreg <= (seq == 2'd0) ? DEV_WR : DEV_RD;
                bitn <= '0; st <= S_TX; scl_ctl <= 1'b1; ph <= 2'd0;
              end
              S_TX: begin
                if (bitn == 3'd7) st <= S_TACK;
                else begin
                  bitn <= bitn + 1'b1; shreg <= {shreg[6:0], 1'b0};
                end
                scl_ctl <= 1'b1; ph <= 2'd0;
              end
              S_TACK: begin
                if (sda_in) begin
                  st <= S_IDLE; busy <= 1'b0; done <= 1'b1; ok <= 1'b0;
                  scl_ctl <= 1'b0; sda_ctl <= 1'b0;
                end else begin
                  scl_ctl <= 1'b1; ph <= 2'd0; bitn <= '0;
                  case (seq)
                    2'd0:    begin seq <= 2'd1; shreg <= 8'h00; st <= S_TX; end
                    2'd1:    begin seq <= 2'd2; st <= S_RPRE; end
                    default: st <= S_RX;
                  endcase
                end
              end
              S_RPRE: begin
                sda_ctl <= 1'b1; st <= S_STA;
              end
              S_RX: begin
                shreg <= {shreg[6:0], sda_in};
                if (bitn == 3'd7) begin
                  rx_data <= {shreg[6:0], sda_in}; rx_valid <= 1'b1; st <= S_MACK;
                end else bitn <= bitn + 1'b1;
                scl_ctl <= 1'b1; ph <= 2'd0;
              end
              S_MACK: begin
                nrx <= nrx + 1'b1;
                if (last) begin
                  st <= S_STP; tries <= '0;
                end else begin
                  st <= S_RX; bitn <= '0;
                end
                scl_ctl <= 1'b1; ph <= 2'd0;
              end
              S_STP: begin
                sda_ctl <= 1'b0; st <= S_SCHK;
              end
              S_SCHK: begin
                if (sda_in || try_end) begin
                  st <= S_IDLE; busy <= 1'b0; done <= 1'b1; ok <= sda_in;
                  scl_ctl <= 1'b0; sda_ctl <= 1'b0;
                end else begin
                  tries <= tries + 1'b1; st <= S_STP; scl_ctl <= 1'b1; ph <= 2'd0;
                end
              end
              default: st <= S_IDLE;
            endcase
          end
        end
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_ctl && !sda_ctl)); // R1
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tmr != '0) |-> ($stable(scl_ctl) && $stable(sda_ctl))); // R2
  AST_DATA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scl_ctl && !$past(scl_ctl) && !$stable(sda_ctl)) |-> (st == S_STA || st == S_SCHK)); // R3
  AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tries < RW'(TRIES))); // R5
  AST_VALID_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (busy && scl_ctl && st == S_MACK)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9
  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cnt_q)); // R10
endmodule

// File: tb/sim_eeprom_seq_reader.sv
`timescale 1ns/1ps
module sim_eeprom_seq_reader;
  localparam int H  = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0, start = 1'b0, sda_in = 1'b1;
  logic [CW-1:0] count = '0;
  logic          scl_ctl, sda_ctl, busy, rx_valid, done, ok;
  logic [7:0]    rx_data;

  eeprom_seq_reader #(.HALF_CYC(H), .CNT_W(CW), .TRIES(10)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count),
    .scl_ctl(scl_ctl), .sda_ctl(sda_ctl), .sda_in(sda_in),
    .busy(busy), .rx_data(rx_data), .rx_valid(rx_valid), .done(done), .ok(ok));

  typedef struct packed {
    logic scl; logic sda; logic pull; logic busy;
    logic valid; logic done; logic ok; logic [7:0] data;
  } exp_t;

  exp_t q[$];
  logic m_sda;
  int   n_chk = 0, n_bad = 0;
  bit   finished = 0;

  task automatic chk(input bit good, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic slot(input logic scl, input logic sda, input logic pull, input logic v, input logic [7:0] d);
    exp_t e;
    for (int i = 0; i < H; i++) begin
      e.scl = scl; e.sda = sda; e.pull = pull; e.busy = 1'b1;
      e.valid = v && (i == 0); e.done = 1'b0; e.ok = 1'b0; e.data = d;
      q.push_back(e);
    end
  endtask

  task automatic pulse(input logic d, input logic pull, input logic v, input logic [7:0] dat);
    slot(1'b1, m_sda, pull, v, dat);
    slot(1'b1, d, pull, 1'b0, 8'h00);
    slot(1'b0, d, pull, 1'b0, 8'h00);
    m_sda = d;
  endtask

  task automatic fin(input logic res);
    exp_t e;
    e = '0; e.done = 1'b1; e.ok = res;
    q.push_back(e);
  endtask

  task automatic txb(input logic [7:0] x, input logic ack);
    for (int b = 7; b >= 0; b--) pulse(!x[b], 1'b0, 1'b0, 8'h00);
    pulse(1'b0, ack, 1'b0, 8'h00);
  endtask

  task automatic build(input int stuck, input int nack_at, input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input int nb, input int stop_low);
    logic [7:0] bs [3];
    bit freed;
    bs[0] = b0; bs[1] = b1; bs[2] = b2;
    q.delete(); m_sda = 1'b0; freed = 0;
    slot(1'b0, 1'b0, stuck > 0, 1'b0, 8'h00);
    if (stuck > 0) begin
      for (int s = 1; s <= 10; s++) begin
        pulse(1'b0, s < stuck, 1'b0, 8'h00);
        if (!(s < stuck)) begin freed = 1; break; end
      end
      if (!freed) begin fin(1'b0); return; end
    end
    slot(1'b0, 1'b1, 1'b0, 1'b0, 8'h00); m_sda = 1'b1;
    txb(8'hA0, nack_at != 0);
    if (nack_at == 0) begin fin(1'b0); return; end
    txb(8'h00, nack_at != 1);
    if (nack_at == 1) begin fin(1'b0); return; end
    pulse(1'b0, 1'b0, 1'b0, 8'h00);
    slot(1'b0, 1'b1, 1'b0, 1'b0, 8'h00); m_sda = 1'b1;
    txb(8'hA1, nack_at != 2);
    if (nack_at == 2) begin fin(1'b0); return; end
    for (int k = 0; k < nb; k++) begin
      for (int b = 7; b >= 0; b--) pulse(1'b0, !bs[k][b], 1'b0, 8'h00);
      pulse((k == nb - 1) ? 1'b0 : 1'b1, 1'b0, 1'b1, bs[k]);
    end
    for (int a = 0; a < 10; a++) begin
      pulse(1'b1, 1'b0, 1'b0, 8'h00);
      slot(1'b0, 1'b0, a < stop_low, 1'b0, 8'h00); m_sda = 1'b0;
      if (!(a < stop_low)) begin fin(1'b1); return; end
    end
    fin(1'b0);
  endtask

  task automatic run(input int stuck, input int nack_at, input logic [7:0] b0, input logic [7:0] b1,
                     input logic [7:0] b2, input int nb, input int stop_low, input int inj, input string tag);
    exp_t e;
    build(stuck, nack_at, b0, b1, b2, nb, stop_low);
    @(negedge clk);
    start = 1'b1; count = CW'(nb);
    for (int i = 0; i < q.size(); i++) begin
      e = q[i];
      @(negedge clk);
      sda_in = !(sda_ctl | e.pull);
      if (i == inj) begin start = 1'b1; count = 8'd7; end
      else start = 1'b0;
      if (i == 0)
        chk(busy && !scl_ctl && !sda_ctl, "R2", "busy/lines after accept",
            {29'd0, busy, scl_ctl, sda_ctl}, 4);
      chk({scl_ctl, sda_ctl, busy} == {e.scl, e.sda, e.busy}, tag, "scl_ctl/sda_ctl/busy",
          {29'd0, scl_ctl, sda_ctl, busy}, {29'd0, e.scl, e.sda, e.busy});
      chk(rx_valid == e.valid && (!e.valid || rx_data == e.data), "R7", "rx_valid/rx_data",
          {23'd0, rx_valid, rx_data}, {23'd0, e.valid, e.data});
      chk(done == e.done && (!e.done || ok == e.ok), "R9", "done/ok",
          {30'd0, done, ok}, {30'd0, e.done, e.ok});
    end
    start = 1'b0; sda_in = 1'b1; count = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !scl_ctl && !sda_ctl, "R10", "idle after run, no queued start",
        {29'd0, busy, done, scl_ctl}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_ctl && !sda_ctl && !busy && !done && !rx_valid, "R1", "reset state",
        {27'd0, scl_ctl, sda_ctl, busy, done, rx_valid}, 0);
    run(0, -1, 8'h5A, 8'hC3, 8'h01, 3, 0, -1, "R3");
    run(0, -1, 8'hFF, 8'h00, 8'h00, 2, 0, -1, "R4");
    run(3, -1, 8'hA5, 8'h00, 8'h00, 1, 0, -1, "R5");
    run(11, -1, 8'h00, 8'h00, 8'h00, 1, 0, -1, "R5");
    run(0, 1, 8'h00, 8'h00, 8'h00, 1, 0, -1, "R6");
    run(0, 2, 8'h00, 8'h00, 8'h00, 1, 0, -1, "R6");
    run(0, -1, 8'h3C, 8'h00, 8'h00, 1, 2, -1, "R8");
    run(0, -1, 8'h81, 8'h00, 8'h00, 1, 10, -1, "R8");
    run(0, -1, 8'h12, 8'h34, 8'h00, 2, 0, 40, "R10");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=complete");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule